// File: doc/BRIEF.md
# Queue-Pair Remote-Read Frontend

This block sits beside one core. It links that core to a remote-memory network interface whose data path lives at the chip edge. The core and the frontend share two rings in cacheable memory. In the work ring the core places remote-read descriptors. In the completion ring the frontend reports finished requests. All accesses to both rings stay local to the core tile. The frontend polls the work ring through a single-entry read port. It takes an entry as new only when the entry's phase bit matches the phase the frontend expects. It then presents the descriptor as a request packet on a valid/ready on-chip network port that leads to the edge unit.

When the edge unit has collected every reply for a request, it returns a completion packet carrying the tag and a status. The frontend matches the tag against its set of outstanding tags. On a match it writes a completion entry at its completion-ring tail, with a phase bit the core can poll. Each ring side reverses its phase on every wrap, so neither side needs a shared fill counter. Issue is throttled in two ways: by a limit on outstanding tags, and by refusing a tag that is already in flight. Completions are back-pressured when the core has not yet freed space in the completion ring.

Top module: `qpf_frontend`

## Requirements
- R1: While reset is asserted and in the first cycle after it, req_valid and cq_wr_en are 0. Both ring pointers start at index 0, and the expected work phase is 1.
- R2: A work entry is {phase(1), node(8), offset(32), local address(32), length(16), tag(8)}, with phase as the MSB. An entry whose phase equals the expected phase is sent as one request packet, and its node, offset, local address, length and tag are carried unchanged. Packets leave in ring order.
- R3: An entry whose phase differs from the expected phase is stale. It produces no packet, and the frontend keeps polling the same index.
- R4: The work head advances by one per accepted packet, modulo WQ_DEPTH. The expected phase reverses each time the head wraps, so entries of the second pass carry phase 0.
- R5: While req_valid is 1 and req_ready is 0, req_valid stays 1 and all request fields hold their values.
- R6: No packet is offered while MAX_OUT tags are outstanding. A completion that frees a tag lets issue resume.
- R7: A descriptor whose tag is already outstanding is not issued until that tag completes.
- R8: A completion with an outstanding tag writes the entry {phase(1), status(1), tag(8)} at the completion tail in the same cycle the completion is accepted, and frees the tag. Status 0 means success and 1 means remote error.
- R9: A completion whose tag is not outstanding is accepted (cmp_ready 1), writes nothing, and leaves the completion tail unchanged.
- R10: When the completion ring is full, cmp_ready is 0 and nothing is written. core_cq_head is the core's consume index plus a wrap bit, and the ring counts as full when the index parts are equal and the wrap bits differ.
- R11: The completion tail wraps modulo CQ_DEPTH. The written phase bit is 1 on the first pass and reverses on each wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wq_rd_en | output | 1 | Work-ring read request |
| wq_rd_idx | output | log2(WQ_DEPTH) | Work-ring index to read |
| wq_rd_data | input | 97 | Work entry, valid the cycle after wq_rd_en |
| req_valid | output | 1 | Request packet valid |
| req_ready | input | 1 | Network accepts the request packet |
| req_node | output | 8 | Remote node id |
| req_offset | output | 32 | Remote offset |
| req_laddr | output | 32 | Local buffer address |
| req_len | output | 16 | Length in bytes |
| req_tag | output | 8 | Request tag |
| cmp_valid | input | 1 | Completion packet valid |
| cmp_ready | output | 1 | Completion packet accepted |
| cmp_tag | input | 8 | Completed tag |
| cmp_status | input | 1 | 0 success, 1 remote error |
| cq_wr_en | output | 1 | Completion-ring write strobe |
| cq_wr_idx | output | log2(CQ_DEPTH) | Completion-ring index |
| cq_wr_data | output | 10 | Completion entry {phase, status, tag} |
| core_cq_head | input | log2(CQ_DEPTH)+1 | Core consume pointer with wrap bit |

## Verification
The hardest states to reach from the ports come from interactions between the work and completion rings. One is a second-pass work entry carrying phase 0 that must be issued. Another is a duplicate tag that must wait while the limit is not yet reached. A third is a completion that finds the completion ring full. The stimulus uses small rings and a limit of three. It fills the work ring past its wrap while request acceptance is held off, which piles up tags against the limit. It frees tags one at a time to release the stalled entries. It re-posts a still-outstanding tag. Finally it drives the core's consume pointer to exactly one lap behind the tail, so that a pending completion must stall and then land at the correct index once space is freed.

// File: rtl/qpf_pkg.sv
package qpf_pkg;
  parameter int NODE_W = 8;
  parameter int OFF_W  = 32;
  parameter int ADDR_W = 32;
  parameter int LEN_W  = 16;
  parameter int TAG_W  = 8;

  localparam int DESC_W = 1 + NODE_W + OFF_W + ADDR_W + LEN_W + TAG_W;
  localparam int CQE_W  = 2 + TAG_W;
  localparam int NTAGS  = 1 << TAG_W;

  typedef struct packed {
    logic              phase;
    logic [NODE_W-1:0] node;
    logic [OFF_W-1:0]  offset;
    logic [ADDR_W-1:0] laddr;
    logic [LEN_W-1:0]  len;
    logic [TAG_W-1:0]  tag;
  } wq_desc_t;

  typedef struct packed {
    logic             phase;
    logic             status;
    logic [TAG_W-1:0] tag;
  } cq_entry_t;

  typedef enum logic [1:0] {ST_POLL, ST_CHECK, ST_SEND} poll_state_t;
endpackage

// File: rtl/qpf_wq_poller.sv
module qpf_wq_poller
  import qpf_pkg::*;
#(
  parameter int WQ_DEPTH = 16,
  localparam int WQ_AW = $clog2(WQ_DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             wq_rd_en,
  output logic [WQ_AW-1:0] wq_rd_idx,
  input  wq_desc_t         rd_desc,
  output logic [TAG_W-1:0] query_tag,
  input  logic             tag_ok,
  output logic             req_valid,
  input  logic             req_ready,
  output wq_desc_t         pend,
  output logic             issue
);
  poll_state_t    state, state_nx;
  logic [WQ_AW:0] head, head_nx;
  wq_desc_t       pend_nx;
  logic           exp_phase;
  logic           fresh;

  // Expected phase is 1 on the first lap and flips on every wrap.
  assign exp_phase = ~head[WQ_AW];
  assign fresh     = (state == ST_CHECK) && (rd_desc.phase == exp_phase);
  assign query_tag = rd_desc.tag;
  assign wq_rd_idx = head[WQ_AW-1:0];
  assign req_valid = (state == ST_SEND);
  assign issue     = req_valid && req_ready;

  always_comb begin
    state_nx = state;
    head_nx  = head;
    pend_nx  = pend;
    wq_rd_en = 1'b0;
    case (state)
      ST_POLL: begin
        wq_rd_en = 1'b1;
        state_nx = ST_CHECK;
      end
      ST_CHECK: begin
        if (fresh && tag_ok) begin
          pend_nx  = rd_desc;
          state_nx = ST_SEND;
        end else begin
          state_nx = ST_POLL;
        end
      end
      ST_SEND: begin
        if (req_ready) begin
          head_nx  = head + 1'b1;
          state_nx = ST_POLL;
        end
      end
      default: state_nx = ST_POLL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_POLL;
      head  <= '0;
      pend  <= '0;
    end else begin
      state <= state_nx;
      head  <= head_nx;
      pend  <= pend_nx;
    end
  end
endmodule

// File: rtl/qpf_tag_tracker.sv
module qpf_tag_tracker
  import qpf_pkg::*;
#(
  parameter int MAX_OUT = 16,
  localparam int CNT_W = $clog2(MAX_OUT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TAG_W-1:0] query_tag,
  output logic             tag_ok,
  input  logic             alloc,
  input  logic [TAG_W-1:0] alloc_tag,
  input  logic             rel_req,
  input  logic [TAG_W-1:0] rel_tag,
  output logic             rel_hit,
  output logic [CNT_W-1:0] cnt
);
  logic [NTAGS-1:0] busy, busy_nx;
  logic [CNT_W-1:0] cnt_nx;
  logic             rel;

  assign rel_hit = busy[rel_tag];
  assign rel     = rel_req && rel_hit;
  assign tag_ok  = !busy[query_tag] && (cnt < CNT_W'(MAX_OUT));

  always_comb begin
    busy_nx = busy;
    if (rel)   busy_nx[rel_tag]   = 1'b0;
    if (alloc) busy_nx[alloc_tag] = 1'b1;
    cnt_nx = cnt;
    if (alloc && !rel)      cnt_nx = cnt + 1'b1;
    else if (rel && !alloc) cnt_nx = cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= '0;
      cnt  <= '0;
    end else begin
      if (alloc || rel) begin
        busy <= busy_nx;
        cnt  <= cnt_nx;
      end
    end
  end
endmodule

// File: rtl/qpf_cq_writer.sv
module qpf_cq_writer
  import qpf_pkg::*;
#(
  parameter int CQ_DEPTH = 16,
  localparam int CQ_AW = $clog2(CQ_DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_valid,
  input  logic [TAG_W-1:0] cmp_tag,
  input  logic             cmp_status,
  input  logic             hit,
  input  logic [CQ_AW:0]   core_cq_head,
  output logic             cmp_ready,
  output logic             accept,
  output logic             cq_wr_en,
  output logic [CQ_AW-1:0] cq_wr_idx,
  output cq_entry_t        cq_entry
);
  logic [CQ_AW:0] tail, tail_nx;
  logic           full;

  assign full = (tail[CQ_AW-1:0] == core_cq_head[CQ_AW-1:0]) &&
                (tail[CQ_AW] != core_cq_head[CQ_AW]);
  assign cmp_ready = !full;
  assign accept    = cmp_valid && cmp_ready;
  assign cq_wr_en  = accept && hit;
  assign cq_wr_idx = tail[CQ_AW-1:0];

  always_comb begin
    cq_entry.phase  = ~tail[CQ_AW];
    cq_entry.status = cmp_status;
    cq_entry.tag    = cmp_tag;
    tail_nx = tail + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tail <= '0;
    else if (cq_wr_en) tail <= tail_nx;
  end
endmodule

// File: rtl/qpf_frontend.sv
module qpf_frontend
  import qpf_pkg::*;
#(
  parameter int WQ_DEPTH = 16,
  parameter int CQ_DEPTH = 16,
  parameter int MAX_OUT  = 16,
  localparam int WQ_AW = $clog2(WQ_DEPTH),
  localparam int CQ_AW = $clog2(CQ_DEPTH),
  localparam int CNT_W = $clog2(MAX_OUT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              wq_rd_en,
  output logic [WQ_AW-1:0]  wq_rd_idx,
  input  logic [DESC_W-1:0] wq_rd_data,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [NODE_W-1:0] req_node,
  output logic [OFF_W-1:0]  req_offset,
  output logic [ADDR_W-1:0] req_laddr,
  output logic [LEN_W-1:0]  req_len,
  output logic [TAG_W-1:0]  req_tag,
  input  logic              cmp_valid,
  output logic              cmp_ready,
  input  logic [TAG_W-1:0]  cmp_tag,
  input  logic              cmp_status,
  output logic              cq_wr_en,
  output logic [CQ_AW-1:0]  cq_wr_idx,
  output logic [CQE_W-1:0]  cq_wr_data,
  input  logic [CQ_AW:0]    core_cq_head
);
  wq_desc_t         rd_desc;
  wq_desc_t         pend;
  cq_entry_t        cq_entry;
  logic [TAG_W-1:0] query_tag;
  logic             tag_ok;
  logic             issue;
  logic             accept;
  logic             hit;
  logic [CNT_W-1:0] out_cnt;

  assign rd_desc    = wq_desc_t'(wq_rd_data);
  assign req_node   = pend.node;
  assign req_offset = pend.offset;
  assign req_laddr  = pend.laddr;
  assign req_len    = pend.len;
  assign req_tag    = pend.tag;
  assign cq_wr_data = cq_entry;

  qpf_wq_poller #(.WQ_DEPTH(WQ_DEPTH)) u_poll (
    .clk(clk), .rst_n(rst_n),
    .wq_rd_en(wq_rd_en), .wq_rd_idx(wq_rd_idx), .rd_desc(rd_desc),
    .query_tag(query_tag), .tag_ok(tag_ok),
    .req_valid(req_valid), .req_ready(req_ready),
    .pend(pend), .issue(issue)
  );

  qpf_tag_tracker #(.MAX_OUT(MAX_OUT)) u_tags (
    .clk(clk), .rst_n(rst_n),
    .query_tag(query_tag), .tag_ok(tag_ok),
    .alloc(issue), .alloc_tag(pend.tag),
    .rel_req(accept), .rel_tag(cmp_tag), .rel_hit(hit),
    .cnt(out_cnt)
  );

  qpf_cq_writer #(.CQ_DEPTH(CQ_DEPTH)) u_cq (
    .clk(clk), .rst_n(rst_n),
    .cmp_valid(cmp_valid), .cmp_tag(cmp_tag), .cmp_status(cmp_status),
    .hit(hit), .core_cq_head(core_cq_head),
    .cmp_ready(cmp_ready), .accept(accept),
    .cq_wr_en(cq_wr_en), .cq_wr_idx(cq_wr_idx), .cq_entry(cq_entry)
  );
endmodule

// File: rtl/qpf_frontend_chk.sv
module qpf_frontend_chk
  import qpf_pkg::*;
#(
  parameter int WQ_DEPTH = 16,
  parameter int CQ_DEPTH = 16,
  parameter int MAX_OUT  = 16,
  localparam int WQ_AW = $clog2(WQ_DEPTH),
  localparam int CQ_AW = $clog2(CQ_DEPTH),
  localparam int CNT_W = $clog2(MAX_OUT + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wq_rd_en,
  input logic [WQ_AW-1:0]  wq_rd_idx,
  input logic              req_valid,
  input logic              req_ready,
  input logic [NODE_W-1:0] req_node,
  input logic [OFF_W-1:0]  req_offset,
  input logic [ADDR_W-1:0] req_laddr,
  input logic [LEN_W-1:0]  req_len,
  input logic [TAG_W-1:0]  req_tag,
  input logic              cmp_valid,
  input logic              cmp_ready,
  input logic [TAG_W-1:0]  cmp_tag,
  input logic              cq_wr_en,
  input logic [CQ_AW-1:0]  cq_wr_idx,
  input logic [CQE_W-1:0]  cq_wr_data,
  input logic [CQ_AW:0]    core_cq_head,
  input logic [CNT_W-1:0]  out_cnt
);
  logic [WQ_AW:0]   m_head;
  logic [CQ_AW:0]   m_tail;
  logic [NTAGS-1:0] m_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_head <= '0;
      m_tail <= '0;
      m_busy <= '0;
    end else begin
      if (req_valid && req_ready) begin
        m_head <= m_head + 1'b1;
        m_busy[req_tag] <= 1'b1;
      end
      if (cq_wr_en) begin
        m_tail <= m_tail + 1'b1;
        m_busy[cq_wr_data[TAG_W-1:0]] <= 1'b0;
      end
    end
  end

  p_rd_index_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wq_rd_en |-> wq_rd_idx == m_head[WQ_AW-1:0]);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_tag) && $stable(req_node)
      && $stable(req_offset) && $stable(req_laddr) && $stable(req_len));

  p_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> out_cnt < CNT_W'(MAX_OUT));

  p_unique_tag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !m_busy[req_tag]);

  p_cq_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cq_wr_en |-> cq_wr_idx == m_tail[CQ_AW-1:0] && m_busy[cq_wr_data[TAG_W-1:0]]);

  p_stray_cmp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid && cmp_ready && !m_busy[cmp_tag] |-> !cq_wr_en);

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cq_wr_en |-> !((m_tail[CQ_AW-1:0] == core_cq_head[CQ_AW-1:0]) &&
                   (m_tail[CQ_AW] != core_cq_head[CQ_AW])));

  p_cq_phase_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cq_wr_en |-> cq_wr_data[CQE_W-1] == ~m_tail[CQ_AW]);
endmodule

bind qpf_frontend qpf_frontend_chk #(
  .WQ_DEPTH(WQ_DEPTH), .CQ_DEPTH(CQ_DEPTH), .MAX_OUT(MAX_OUT)
) u_chk (.*);

// File: tb/qpf_frontend_tb.sv
module qpf_frontend_tb;
  import qpf_pkg::*;

  localparam int WQD = 4;
  localparam int CQD = 4;
  localparam int LIM = 3;
  localparam int WAW = $clog2(WQD);
  localparam int CAW = $clog2(CQD);

  logic clk;
  logic rst_n;
  logic              wq_rd_en;
  logic [WAW-1:0]    wq_rd_idx;
  logic [DESC_W-1:0] wq_rd_data;
  logic              req_valid, req_ready;
  logic [NODE_W-1:0] req_node;
  logic [OFF_W-1:0]  req_offset;
  logic [ADDR_W-1:0] req_laddr;
  logic [LEN_W-1:0]  req_len;
  logic [TAG_W-1:0]  req_tag;
  logic              cmp_valid, cmp_ready, cmp_status;
  logic [TAG_W-1:0]  cmp_tag;
  logic              cq_wr_en;
  logic [CAW-1:0]    cq_wr_idx;
  logic [CQE_W-1:0]  cq_wr_data;
  logic [CAW:0]      core_cq_head;

  qpf_frontend #(.WQ_DEPTH(WQD), .CQ_DEPTH(CQD), .MAX_OUT(LIM)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .wq_rd_en(wq_rd_en), .wq_rd_idx(wq_rd_idx), .wq_rd_data(wq_rd_data),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_node(req_node), .req_offset(req_offset), .req_laddr(req_laddr),
    .req_len(req_len), .req_tag(req_tag),
    .cmp_valid(cmp_valid), .cmp_ready(cmp_ready), .cmp_tag(cmp_tag),
    .cmp_status(cmp_status),
    .cq_wr_en(cq_wr_en), .cq_wr_idx(cq_wr_idx), .cq_wr_data(cq_wr_data),
    .core_cq_head(core_cq_head)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  bit auto_consume = 1;
  int wq_posts = 0;
  int cq_writes_exp = 0;

  wq_desc_t wq_mem [WQD];
  wq_desc_t pkt_q[$];
  wq_desc_t held_q[$];
  logic [CAW+CQE_W-1:0] cq_q[$];

  always @(posedge clk) if (wq_rd_en) wq_rd_data <= wq_mem[wq_rd_idx];

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // Scoreboard monitor: samples 2 ns after the falling edge.
  always @(negedge clk) begin
    #2;
    if (rst_n && !finished) begin
      if (req_valid && req_ready) begin
        if (pkt_q.size() == 0) chk(0, "R3/R6/R7 unexpected packet tag", req_tag, 0);
        else begin
          wq_desc_t e;
          e = pkt_q.pop_front();
          chk(req_tag == e.tag && req_node == e.node && req_offset == e.offset &&
              req_laddr == e.laddr && req_len == e.len,
              "R2 packet fields/order (tag)", req_tag, e.tag);
        end
      end
      if (cq_wr_en) begin
        if (cq_q.size() == 0) chk(0, "R9 unexpected completion write", cq_wr_data, 0);
        else begin
          logic [CAW+CQE_W-1:0] x;
          x = cq_q.pop_front();
          chk({cq_wr_idx, cq_wr_data} == x, "R8/R11 completion {idx,phase,status,tag}",
              {cq_wr_idx, cq_wr_data}, x);
        end
        if (auto_consume) core_cq_head <= core_cq_head + 1'b1;
      end
    end
  end

  task automatic post(input logic [TAG_W-1:0] tag, input int seed, input bit expect_now);
    wq_desc_t d;
    d.phase  = ((wq_posts / WQD) % 2) == 0;
    d.node   = NODE_W'(seed + 3);
    d.offset = OFF_W'(32'h1000 * seed + 32'h40);
    d.laddr  = ADDR_W'(32'h8000_0000 + seed * 64);
    d.len    = LEN_W'(64 * (seed + 1));
    d.tag    = tag;
    wq_mem[wq_posts % WQD] = d;
    wq_posts++;
    if (expect_now) pkt_q.push_back(d);
    else held_q.push_back(d);
  endtask

  task automatic release_one();
    pkt_q.push_back(held_q.pop_front());
  endtask

  task automatic complete(input logic [TAG_W-1:0] tag, input logic st, input bit matched);
    bit rdy;
    if (matched) begin
      cq_q.push_back({CAW'(cq_writes_exp % CQD), ((cq_writes_exp / CQD) % 2) == 0, st, tag});
      cq_writes_exp++;
    end
    @(negedge clk);
    cmp_valid = 1'b1; cmp_tag = tag; cmp_status = st;
    forever begin
      #1 rdy = cmp_ready;
      @(negedge clk);
      if (rdy) break;
    end
    cmp_valid = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < WQD; i++) wq_mem[i] = '0;
    rst_n = 1'b0; req_ready = 1'b0; cmp_valid = 1'b0; cmp_tag = '0; cmp_status = 1'b0;
    core_cq_head = '0;
    wait_cyc(3);
    #3;
    chk(req_valid == 1'b0, "R1 req_valid in reset", req_valid, 0);
    chk(cq_wr_en == 1'b0, "R1 cq_wr_en in reset", cq_wr_en, 0);
    @(negedge clk); rst_n = 1'b1;
    #3;
    chk(req_valid == 1'b0, "R1 req_valid after reset", req_valid, 0);

    // R2: two fresh entries, R3: slot 2 stays stale (phase 0)
    req_ready = 1'b1;
    post(8'd1, 1, 1);
    post(8'd2, 2, 1);
    wait_cyc(25);
    chk(pkt_q.size() == 0, "R2 both packets issued", pkt_q.size(), 0);
    #3 chk(req_valid == 1'b0, "R3 stale entry not issued", req_valid, 0);

    // R9 stray completion, R8 matched completions
    complete(8'd99, 1'b0, 0);
    complete(8'd1, 1'b0, 1);
    complete(8'd2, 1'b1, 1);
    wait_cyc(3);
    chk(cq_q.size() == 0, "R8 completions written", cq_q.size(), 0);

    // R5 hold, R6 limit, R4 wrap
    req_ready = 1'b0;
    post(8'd10, 3, 0);
    post(8'd11, 4, 0);
    post(8'd12, 5, 0);
    post(8'd13, 6, 0);
    wait_cyc(10);
    #3;
    chk(req_valid == 1'b1, "R5 valid held", req_valid, 1);
    chk(req_tag == 8'd10, "R5 tag held", req_tag, 10);
    @(negedge clk);
    release_one(); release_one(); release_one();
    req_ready = 1'b1;
    wait_cyc(25);
    chk(pkt_q.size() == 0, "R6 three issued", pkt_q.size(), 0);
    #3 chk(req_valid == 1'b0, "R6 limit stalls issue", req_valid, 0);
    release_one();
    complete(8'd10, 1'b0, 1);
    wait_cyc(15);
    chk(pkt_q.size() == 0, "R4 second-lap entry issued", pkt_q.size(), 0);

    // R11 completion wrap, R7 duplicate tag
    complete(8'd11, 1'b0, 1);
    complete(8'd12, 1'b1, 1);
    post(8'd13, 7, 0);
    wait_cyc(20);
    #3 chk(req_valid == 1'b0, "R7 duplicate tag stalled", req_valid, 0);
    chk(cq_q.size() == 0, "R11 wrapped completions written", cq_q.size(), 0);
    release_one();
    complete(8'd13, 1'b0, 1);
    wait_cyc(15);
    chk(pkt_q.size() == 0, "R7 duplicate issued after completion", pkt_q.size(), 0);

    // R10 full completion ring
    @(negedge clk);
    auto_consume = 0;
    core_cq_head = core_cq_head ^ (CAW+1)'(CQD);
    cmp_valid = 1'b1; cmp_tag = 8'd13; cmp_status = 1'b1;
    #2;
    chk(cmp_ready == 1'b0, "R10 ready low when full", cmp_ready, 0);
    wait_cyc(5);
    #2;
    chk(cq_wr_en == 1'b0, "R10 no write when full", cq_wr_en, 0);
    @(negedge clk);
    cmp_valid = 1'b0;
    core_cq_head = core_cq_head ^ (CAW+1)'(CQD);
    auto_consume = 1;
    complete(8'd13, 1'b1, 1);
    wait_cyc(3);
    chk(cq_q.size() == 0, "R10 write lands after space freed", cq_q.size(), 0);
    chk(held_q.size() == 0, "R2 all descriptors released", held_q.size(), 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule